// File: doc/BRIEF.md
# Round-Robin Request Arbiter with Masked Priority

This block shares one resource among a parameterised number of requesters. Each cycle it looks at the request vector and drives a grant vector that is one-hot or all zeros, through a purely combinational path from requests to grant. The only state is a registered eligibility mask. It records which requesters sit above the most recent winner and so get first claim on the next grant.

Two lowest-index-first priority stages run side by side. One sees the requests filtered by the mask and the other sees the raw requests. The filtered result wins whenever it holds any request. Otherwise the raw result is used, which wraps the rotation back to the lowest active requester without a lost cycle. Each stage forms a running OR from bit 0 upward, giving a thermometer vector. The grant is the first set bit of that vector. The next mask is the chosen thermometer shifted up by one place.

The reset input is asynchronous and active low. Its release is synchronised to the clock inside the block.

Top module: `rr_arbiter`

## Requirements
- R1: The grant is always one-hot or all zeros, and every granted bit has its request asserted in the same cycle.
- R2: Whenever at least one request is asserted, some grant is issued in that same cycle (work conserving, with no idle cycles).
- R3: After reset the priority pointer is cleared, so the first grant goes to the lowest-indexed active requester (bit 0 is the lowest index).
- R4: After requester k is granted, the next grant goes to the lowest-indexed active requester whose index is greater than k, if one exists.
- R5: When no active requester lies above the last winner, the grant wraps to the lowest-indexed active requester in the same cycle.
- R6: A cycle with no requests gives an all-zero grant and leaves the rotation position unchanged.
- R7: A lone active requester is granted on every cycle in which it asserts.
- R8: The grant follows a change of requests within the same clock cycle, with no register between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req | input | N_REQ | Request vector, bit i from requester i |
| grant | output | N_REQ | One-hot or zero grant vector |

## Verification
On every cycle the assertions check the grant shape: it is one-hot or zero, it only covers asserted requests, it is non-empty whenever a request is present, and it stays inside the mask while masked requests exist. They also check that the mask keeps the shape of a contiguous upper run and holds still through idle cycles. The order of grants cannot be seen from a single cycle. This covers the rotation past the last winner, the wrap to the lowest requester, the restart after reset and the position kept across idle gaps. The bench shows these by comparing every grant against a reference pointer model, under directed sequences and seeded random request patterns.

// File: rtl/rr_pkg.sv
`timescale 1ns/1ps
package rr_pkg;
  localparam int unsigned RR_DEFAULT_N = 8;
endpackage

// File: rtl/rr_rst_sync.sv
`timescale 1ns/1ps
module rr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/rr_prefix_or.sv
`timescale 1ns/1ps
module rr_prefix_or #(
  parameter int unsigned N = 8
) (
  input  logic [N-1:0] vec,
  output logic [N-1:0] thermo,
  output logic [N-1:0] first
);
  genvar i;
  generate
    for (i = 0; i < N; i++) begin : g_chain
      if (i == 0) begin : g_lsb
        assign thermo[i] = vec[i];
      end else begin : g_up
        assign thermo[i] = thermo[i-1] | vec[i];
      end
    end
  endgenerate

  assign first = thermo & ~{thermo[N-2:0], 1'b0};
endmodule

// File: rtl/rr_mask_reg.sv
`timescale 1ns/1ps
module rr_mask_reg #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         upd_en,
  input  logic [N-1:0] mask_in,
  output logic [N-1:0] mask_q
);
  logic [N-1:0] mask_nx;

  always_comb begin
    mask_nx = mask_q;
    if (upd_en) mask_nx = mask_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= mask_nx;
  end

  // R4: mask is always a contiguous run reaching the top bit, or empty
  a_r4_mask_shape: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mask_q & ~{mask_q[N-2:0], 1'b0}) && (mask_q == '0 || mask_q[N-1]));

  // R6: with no update the mask is held
  a_r6_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_en |=> $stable(mask_q));
endmodule

// File: rtl/rr_arbiter.sv
`timescale 1ns/1ps
module rr_arbiter #(
  parameter int unsigned N_REQ = rr_pkg::RR_DEFAULT_N
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_REQ-1:0] req,
  output logic [N_REQ-1:0] grant
);
  logic             srst_n;
  logic [N_REQ-1:0] mask_q;
  logic [N_REQ-1:0] masked_req;
  logic [N_REQ-1:0] m_thermo, m_first;
  logic [N_REQ-1:0] r_thermo, r_first;
  logic [N_REQ-1:0] sel_thermo;
  logic [N_REQ-1:0] mask_next;
  logic             use_masked;
  logic             any_req;

  rr_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .arst_n(rst_n), .srst_n(srst_n)
  );

  assign masked_req = req & mask_q;

  rr_prefix_or #(.N(N_REQ)) u_masked (
    .vec(masked_req), .thermo(m_thermo), .first(m_first)
  );

  rr_prefix_or #(.N(N_REQ)) u_raw (
    .vec(req), .thermo(r_thermo), .first(r_first)
  );

  always_comb begin
    use_masked = |masked_req;
    any_req    = |req;
    grant      = use_masked ? m_first  : r_first;
    sel_thermo = use_masked ? m_thermo : r_thermo;
    mask_next  = {sel_thermo[N_REQ-2:0], 1'b0};
  end

  rr_mask_reg #(.N(N_REQ)) u_mask (
    .clk(clk), .rst_n(srst_n), .upd_en(any_req),
    .mask_in(mask_next), .mask_q(mask_q)
  );

  // R1: one-hot or zero, and only to asserted requests
  a_r1_onehot: assert property (@(posedge clk) disable iff (!srst_n)
    $onehot0(grant));
  a_r1_subset: assert property (@(posedge clk) disable iff (!srst_n)
    (grant & ~req) == '0);
  // R2: work conserving
  a_r2_work: assert property (@(posedge clk) disable iff (!srst_n)
    (|req) |-> (|grant));
  // R4: eligible requests above the last winner take precedence
  a_r4_in_mask: assert property (@(posedge clk) disable iff (!srst_n)
    (|(req & mask_q)) |-> ((grant & ~mask_q) == '0));
  // R6: no requests, no grant
  a_r6_idle: assert property (@(posedge clk) disable iff (!srst_n)
    (req == '0) |-> (grant == '0));
endmodule

// File: tb/test_rr_arbiter.sv
`timescale 1ns/1ps
module test_rr_arbiter;
  localparam int unsigned N = 8;
  localparam int unsigned MAXCYC = 200000;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [N-1:0] req;
  logic [N-1:0] grant;
  logic [N-1:0] mdl_mask;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rr_arbiter #(.N_REQ(N)) i_rr_arbiter (
    .clk(clk), .rst_n(rst_n), .req(req), .grant(grant)
  );

  function automatic logic [N-1:0] lowest(input logic [N-1:0] v);
    return v & (~v + 1'b1);
  endfunction

  function automatic logic [N-1:0] expect_grant(input logic [N-1:0] r,
                                                input logic [N-1:0] m);
    if ((r & m) != '0) return lowest(r & m);
    return lowest(r);
  endfunction

  function automatic logic [N-1:0] above(input logic [N-1:0] g);
    return ~((g - 1'b1) | g);
  endfunction

  task automatic check(input string tag, input logic [N-1:0] act,
                       input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s grant=%b expected=%b req=%b", tag, act, exp, req);
    end
  endtask

  // apply one request vector for one cycle, check, then advance the model
  task automatic step(input string tag, input logic [N-1:0] v);
    logic [N-1:0] e;
    @(negedge clk);
    req = v;
    #1;
    e = expect_grant(v, mdl_mask);
    check(tag, grant, e);
    @(posedge clk);
    if (v != '0) mdl_mask = above(e);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    req = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    mdl_mask = '0;
  endtask

  initial begin
    logic [N-1:0] v;
    void'($urandom(32'd20240611));
    do_reset();
    // reset state
    #1 check("R6 reset idle", grant, '0);
    step("R3 first grant lowest", 8'b1010_1100);
    // rotation through all requesters then wrap
    for (int k = 0; k < 8; k++) step("R4 rotate all", 8'hFF);
    step("R5 wrap to lowest", 8'hFF);
    // combinational response: change req mid-sequence
    step("R8 same-cycle follow", 8'b0001_0000);
    step("R8 same-cycle follow", 8'b0000_0010);
    // idle cycles keep position
    step("R4 set position", 8'b0000_1000);
    step("R6 idle no grant", 8'h00);
    step("R6 idle no grant", 8'h00);
    step("R6 position held", 8'hFF);
    // wrap when nothing above last winner
    step("R4 take top", 8'b1000_0001);
    step("R5 wrap after top", 8'b1000_0001);
    step("R5 wrap past gap", 8'b0100_0010);
    step("R5 wrap past gap", 8'b0000_0110);
    // lone requester every cycle
    for (int k = 0; k < 6; k++) step("R7 lone requester", 8'b0010_0000);
    for (int k = 0; k < 4; k++) step("R7 lone bit0", 8'b0000_0001);
    // reset mid-run restarts at lowest
    step("R4 advance", 8'b0100_0000);
    do_reset();
    step("R3 after second reset", 8'b0101_0000);
    // random
    for (int k = 0; k < 2000; k++) begin
      case ($urandom_range(0, 3))
        0: v = '0;
        1: v = N'($urandom) & N'($urandom);
        2: v = N'(1) << $urandom_range(0, N-1);
        default: v = N'($urandom);
      endcase
      step("R1 R2 R4 R5 random", v);
    end
    @(negedge clk);
    req = '0;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (MAXCYC) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule